// File: doc/BRIEF.md
# Daisy-Chain Serial Host Sequencer

This block is the host end of a serial link whose data line runs through a string of identical devices. Each device's output feeds the next device's input. One chip-select window carries one transaction. The host supplies one command frame per device slot and pulses `start`. The block then drives chip select, serial clock and data out. The commands are ordered so that, when chip select rises, every device in the string holds the frame that was meant for it. Over the same clocks the block samples the returning line and sorts the bits into per-device receive slots.

Frame length, device count and clock divider are read at `start`, so one instance can serve strings of different sizes. All devices in a string share one frame length. Padding a short command up to that length is done by the host in the slot contents. Reading a device register takes two transactions: the command goes out in the first, and the reply comes back in the second. A configuration whose device count exceeds a supplied limit is flagged and refused. That limit is normally derived from the serial clock rate, the device output rate and the frame length.

Top module: `dch_chain_host`

## Requirements
- R1: Slot i of `tx_frames` is bits [32i+31:32i], and device 0 is nearest the host. Only the low L bits of a slot are sent, where L is `frame_bits`, highest bit first. The frame for device N-1 (N is `dev_count`) goes out first and device 0's frame goes out last, so after the transaction each device's shift register holds its own slot.
- R2: The first L bits sampled from `miso` go into slot N-1 of `rx_frames`, highest bit first, and the last L bits go into slot 0. All bits above L and all slots at N or higher read zero after the transaction.
- R3: A transaction has exactly L×N rising edges of `sclk`.
- R4: `sclk` idles low. Data is sampled on the rising edge and changes after the falling edge. `cs_n` falls on the clock edge that accepts `start`. Every phase lasts `half_div` system clocks: the lead-in before the first rise, each high level, each low level, and the tail from the last fall to `cs_n` rising.
- R5: `busy` is high from the edge that accepts `start` until the edge where `cs_n` rises. `done` is high for exactly the one cycle in which `cs_n` has just risen, and `rx_frames` is complete from that cycle on.
- R6: A configuration is invalid if any of these holds: `dev_count` is 0, above 8, or above `dev_limit`; `frame_bits` is 0 or above 32; `half_div` is 0. `cfg_err` shows the validity of the previous cycle's inputs. A `start` with an invalid configuration is ignored, and `cs_n` stays high.
- R7: In reset and while idle, `cs_n`=1, `sclk`=0 and `mosi`=0. After reset `busy`=0, `done`=0 and `rx_frames` is all zero.
- R8: A `start` pulse during a transaction has no effect on its timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (one-cycle pulse) |
| frame_bits | input | 6 | Frame length L in bits, 1 to 32 |
| dev_count | input | 4 | Number of devices N in the string, 1 to 8 |
| dev_limit | input | 4 | Largest device count the string may have |
| half_div | input | 8 | System clocks per serial-clock half period |
| tx_frames | input | 256 | Command frame per device slot, 32 bits per slot |
| miso | input | 1 | Serial data from the far end of the string |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data into device 0 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when chip select rises |
| cfg_err | output | 1 | Registered flag for an invalid configuration |
| rx_frames | output | 256 | Returned frame per device slot, 32 bits per slot |

## Verification
The bench models the string as N shift registers clocked by `sclk`, preloaded with per-device replies. A design that reversed the slot order, or sent bits lowest-first, would leave each device holding a neighbour's command and would scramble the receive slots. Lengths of 8, 24 and 32 bits and strings of one, three, four and eight devices probe the wrap from one slot to the next. An off-by-one there would add or drop a clock edge, or shift every frame by one bit. Serial clock and chip-select levels are compared against closed-form timing on every cycle, with dividers of 1, 2 and 3. This catches a missing lead-in or tail and a wrong divider. Invalid configurations and a stray `start` mid-transaction must leave the line idle or the waveform unchanged.

// File: rtl/dch_pkg.sv
package dch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_TRAIL = 3'd4
  } dch_state_e;
endpackage

// File: rtl/dch_sck_div.sv
// Half-period timer: tick marks the last system cycle of each serial phase.
module dch_sck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && ((cnt_q + ONE) == half_div);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: the phase counter never runs past the programmed half period
  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_div != '0) |-> (cnt_q < half_div));
endmodule

// File: rtl/dch_cursor.sv
// Bit/slot pointer: walks slot N-1 down to 0, bit L-1 down to 0 inside each slot.
module dch_cursor #(
  parameter int MAX_DEV  = 8,
  parameter int MAX_BITS = 32,
  localparam int BI_W = $clog2(MAX_BITS),
  localparam int DI_W = $clog2(MAX_DEV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            adv,
  input  logic [BI_W-1:0] ld_bit,
  input  logic [DI_W-1:0] ld_dev,
  output logic [BI_W-1:0] bit_idx,
  output logic [DI_W-1:0] dev_idx,
  output logic            last
);
  logic [BI_W-1:0] bit_q, bit_d, top_q, top_d;
  logic [DI_W-1:0] dev_q, dev_d;

  always_comb begin
    bit_d = bit_q;
    dev_d = dev_q;
    top_d = top_q;
    if (load) begin
      bit_d = ld_bit;
      dev_d = ld_dev;
      top_d = ld_bit;
    end else if (adv) begin
      if (bit_q == '0) begin
        bit_d = top_q;
        dev_d = dev_q - DI_W'(1);
      end else begin
        bit_d = bit_q - BI_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      dev_q <= '0;
      top_q <= '0;
    end else begin
      bit_q <= bit_d;
      dev_q <= dev_d;
      top_q <= top_d;
    end
  end

  assign bit_idx = bit_q;
  assign dev_idx = dev_q;
  assign last    = (bit_q == '0) && (dev_q == '0);

  // R3: the sequencer never steps past the final bit of slot 0
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !last);
  // R3: the pointer moves only when told to
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> ($stable(bit_q) && $stable(dev_q)));
endmodule

// File: rtl/dch_chain_host.sv
module dch_chain_host
  import dch_pkg::*;
#(
  parameter int MAX_DEV  = 8,
  parameter int MAX_BITS = 32,
  parameter int DIV_W    = 8,
  localparam int FB_W  = $clog2(MAX_BITS + 1),
  localparam int DC_W  = $clog2(MAX_DEV + 1),
  localparam int BUF_W = MAX_DEV * MAX_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FB_W-1:0]  frame_bits,
  input  logic [DC_W-1:0]  dev_count,
  input  logic [DC_W-1:0]  dev_limit,
  input  logic [DIV_W-1:0] half_div,
  input  logic [BUF_W-1:0] tx_frames,
  input  logic             miso,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic             cfg_err,
  output logic [BUF_W-1:0] rx_frames
);
  localparam int BI_W = $clog2(MAX_BITS);
  localparam int DI_W = $clog2(MAX_DEV);
  localparam int IX_W = $clog2(BUF_W);

  dch_state_e       state_q, state_d;
  logic             sclk_q, sclk_d, cs_n_q, cs_n_d, done_q, done_d, cfg_err_q;
  logic [BUF_W-1:0] tx_q, rx_q, rx_d;
  logic [DIV_W-1:0] hdiv_q;
  logic             cfg_bad, accept, tick, adv, sample, last;
  logic [BI_W-1:0]  bit_idx;
  logic [DI_W-1:0]  dev_idx;
  logic [FB_W-1:0]  fb_m1;
  logic [DC_W-1:0]  dc_m1;
  logic [IX_W-1:0]  cur_ix;

  always_comb begin
    cfg_bad = (dev_count == '0) || (dev_count > DC_W'(MAX_DEV)) ||
              (dev_count > dev_limit) || (frame_bits == '0) ||
              (frame_bits > FB_W'(MAX_BITS)) || (half_div == '0);
    accept  = (state_q == ST_IDLE) && start && !cfg_bad;
    fb_m1   = frame_bits - FB_W'(1);
    dc_m1   = dev_count - DC_W'(1);
    cur_ix  = IX_W'(dev_idx) * IX_W'(MAX_BITS) + IX_W'(bit_idx);
  end

  dch_sck_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(state_q != ST_IDLE),
    .half_div(hdiv_q), .tick(tick)
  );

  dch_cursor #(.MAX_DEV(MAX_DEV), .MAX_BITS(MAX_BITS)) u_cur (
    .clk(clk), .rst_n(rst_n), .load(accept), .adv(adv),
    .ld_bit(fb_m1[BI_W-1:0]), .ld_dev(dc_m1[DI_W-1:0]),
    .bit_idx(bit_idx), .dev_idx(dev_idx), .last(last)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    adv     = 1'b0;
    sample  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        cs_n_d  = 1'b0;
        state_d = ST_LEAD;
      end
      ST_LEAD, ST_LOW: if (tick) begin
        sclk_d  = 1'b1;
        sample  = 1'b1;
        state_d = ST_HIGH;
      end
      ST_HIGH: if (tick) begin
        sclk_d = 1'b0;
        if (last) state_d = ST_TRAIL;
        else begin
          adv     = 1'b1;
          state_d = ST_LOW;
        end
      end
      ST_TRAIL: if (tick) begin
        cs_n_d  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    rx_d = rx_q;
    if (accept)      rx_d = '0;
    else if (sample) rx_d[cur_ix] = miso;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
      cfg_err_q <= 1'b0;
      rx_q      <= '0;
      tx_q      <= '0;
      hdiv_q    <= '0;
    end else begin
      state_q   <= state_d;
      sclk_q    <= sclk_d;
      cs_n_q    <= cs_n_d;
      done_q    <= done_d;
      cfg_err_q <= cfg_bad;
      rx_q      <= rx_d;
      if (accept) begin
        tx_q   <= tx_frames;
        hdiv_q <= half_div;
      end
    end
  end

  assign sclk      = sclk_q;
  assign cs_n      = cs_n_q;
  assign mosi      = (state_q != ST_IDLE) && tx_q[cur_ix];
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign cfg_err   = cfg_err_q;
  assign rx_frames = rx_q;

  // R7: line quiet whenever chip select is high
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && !mosi));
  // R5: busy only inside the chip-select window
  assert_busy_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);
  // R5: done coincides with the chip-select rise
  assert_done_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));
  // R4: the serial clock moves only on a divider tick
  assert_sclk_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sclk));
  // R6: an invalid configuration never opens a window
  assert_reject_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cfg_bad) |=> (!busy && cs_n));
  // R8: a start during a transaction leaves its timing setting alone
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(hdiv_q));
endmodule

// File: tb/sim_dch_chain_host.sv
`timescale 1ns/1ps
module sim_dch_chain_host;
  logic         clk, rst_n, start, miso;
  logic [5:0]   frame_bits;
  logic [3:0]   dev_count, dev_limit;
  logic [7:0]   half_div;
  logic [255:0] tx_frames, rx_frames;
  logic         sclk, cs_n, mosi, busy, done, cfg_err;

  int checks = 0;
  int errors = 0;
  int L = 8;
  int N = 1;
  int rise_cnt = 0;
  logic [31:0] cmd [8];
  logic [31:0] resp [8];
  logic [31:0] devreg [8];

  dch_chain_host u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_bits(frame_bits),
    .dev_count(dev_count), .dev_limit(dev_limit), .half_div(half_div),
    .tx_frames(tx_frames), .miso(miso), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .busy(busy), .done(done), .cfg_err(cfg_err),
    .rx_frames(rx_frames)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural string of devices: each samples its input on the rising edge
  assign miso = devreg[N-1][L-1];
  always @(posedge sclk) begin
    rise_cnt++;
    for (int i = N - 1; i >= 1; i--) devreg[i] = {devreg[i][30:0], devreg[i-1][L-1]};
    devreg[0] = {devreg[0][30:0], mosi};
  end

  function automatic logic [31:0] lmask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input int l, input int n, input int h, input bit stray);
    int t, last;
    L = l; N = n;
    for (int i = 0; i < 8; i++) begin
      cmd[i]  = 32'hC3A5_0F96 ^ (32'h1357_9BDF * (i + l + 1));
      resp[i] = 32'h6B2E_D481 ^ (32'h2468_ACE1 * (i + 3 * h + 1));
      tx_frames[i*32 +: 32] = cmd[i];
      devreg[i] = resp[i] & lmask(l);
    end
    rise_cnt   = 0;
    frame_bits = 6'(l);
    dev_count  = 4'(n);
    dev_limit  = 4'd8;
    half_div   = 8'(h);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    t    = l * n;
    last = h * (2 * t + 1);
    for (int k = 1; k <= last + 1; k++) begin
      chk("R4 cs_n", {31'b0, cs_n}, (k <= last) ? 32'd0 : 32'd1);
      chk("R4 sclk", {31'b0, sclk}, (k <= last && ((k - 1) / h) % 2 == 1) ? 32'd1 : 32'd0);
      chk("R5 busy", {31'b0, busy}, (k <= last) ? 32'd1 : 32'd0);
      chk("R5 done", {31'b0, done}, (k == last + 1) ? 32'd1 : 32'd0);
      start = (stray && k == 4) ? 1'b1 : 1'b0;  // R8: stray start mid-window
      @(negedge clk);
    end
    start = 1'b0;
    chk("R3 rising edges", 32'(rise_cnt), 32'(t));
    for (int i = 0; i < n; i++)
      chk("R1 device holds own frame", devreg[i] & lmask(l), cmd[i] & lmask(l));
    for (int i = 0; i < 8; i++)
      chk("R2 rx slot", rx_frames[i*32 +: 32], (i < n) ? (resp[i] & lmask(l)) : 32'd0);
    chk("R7 idle mosi", {31'b0, mosi}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    frame_bits = 6'd8; dev_count = 4'd1; dev_limit = 4'd8; half_div = 8'd1;
    tx_frames = '0;
    for (int i = 0; i < 8; i++) devreg[i] = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset cs_n", {31'b0, cs_n}, 32'd1);
    chk("R7 reset sclk", {31'b0, sclk}, 32'd0);
    chk("R7 reset mosi", {31'b0, mosi}, 32'd0);
    chk("R7 reset busy", {31'b0, busy}, 32'd0);
    chk("R7 reset done", {31'b0, done}, 32'd0);
    chk("R7 reset rx", {31'b0, |rx_frames}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_txn(24, 3, 2, 1'b0);
    run_txn(32, 4, 1, 1'b1);
    run_txn(8, 1, 3, 1'b0);
    run_txn(32, 8, 1, 1'b0);
    run_txn(16, 2, 2, 1'b1);

    // R6: device count above the supplied limit
    frame_bits = 6'd8; dev_count = 4'd5; dev_limit = 4'd4; half_div = 8'd1;
    @(negedge clk);
    chk("R6 cfg_err over limit", {31'b0, cfg_err}, 32'd1);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk("R6 rejected cs_n", {31'b0, cs_n}, 32'd1);
      chk("R6 rejected busy", {31'b0, busy}, 32'd0);
      @(negedge clk);
    end
    dev_limit = 4'd8;
    @(negedge clk);
    chk("R6 cfg_err cleared", {31'b0, cfg_err}, 32'd0);
    frame_bits = 6'd0;
    @(negedge clk);
    chk("R6 cfg_err zero length", {31'b0, cfg_err}, 32'd1);
    frame_bits = 6'd33;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R6 cfg_err long frame", {31'b0, cfg_err}, 32'd1);
    chk("R6 long frame rejected", {31'b0, busy}, 32'd0);
    frame_bits = 6'd8;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule